// File: doc/BRIEF.md
# Multi-Channel Clock Rate Monitor

This block measures the frequency of several free-running clocks that are asynchronous to each other and to the rest of the system. Every measured clock drives its own counter in its own domain, and that counter is handed to a reference domain as a registered Gray code. The reference domain runs a gate timer of programmable length. At each window boundary it takes a snapshot of every counter. The count difference against the previous snapshot is the number of rising edges seen in one window.

Each per-channel result goes back to a register interface on a separate bus clock. A result register is held stable while a toggle announces it, and the bus side captures the value when the synchronized toggle flips. Software writes the gate length in reference cycles and polls a status word of per-channel valid flags. It reads each result and divides by the window time to get a frequency.

Top module: `clkrate_monitor`

## Requirements
- R1: After reset the gate register reads DEF_GATE (50,000,000 by default), the status word reads 0 and every result register reads 0.
- R2: Register offsets: 0 is the gate length (read/write), 1 is the status word (bit i is channel i's valid flag), 2+i is channel i's result zero-extended to DATA_W. Any other offset reads 0. Read data is registered and appears on reg_rdata one bus cycle after reg_rd is sampled.
- R3: A gate write below 16 is stored as 16, and the reference domain never runs a window shorter than 16 reference cycles.
- R4: A channel result equals the number of rising edges of that measured clock within one window of gate-length reference cycles. The count is exact when the clock is phase locked to the reference, and within one count otherwise.
- R5: A gate write restarts the window in the reference domain and discards the partial window. The first result after the write covers a full window of the new length.
- R6: The valid flag of channel i is set when a new result for that channel reaches the bus domain. A read of result i clears it, and a read leaves the other channels' flags unchanged.
- R7: A measured clock that never toggles reports a result of 0 after every window.
- R8: Results are computed modulo 2^CNT_W, so a counter wrap inside a window still gives the window count modulo 2^CNT_W.
- R9: A measured counter's Gray value changes by at most one bit per measured-clock cycle.
- R10: Every window end produces a fresh result for every channel. The value handed to the bus side stays stable until its toggle flips.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_clk | input | 1 | Register interface clock |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | ADDR_W (3) | Register offset |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Registered read data |
| ref_clk | input | 1 | Reference clock that times the gate window |
| meas_clk | input | NCH (4) | Clocks under measurement, bit i is channel i |

## Verification
The hardest situations to reach from the ports are a counter wrap inside a window and a gate write that lands in the middle of a window. A 32-bit counter would take billions of edges to wrap. The bench therefore builds the block with 8-bit counters, so the wrap happens every few windows, and it checks a window whose count exceeds 255 against the count modulo 256. To test the restart, the bench waits for a fresh result from a long window, clears the flags and writes a short gate at once. The next result must then show the short window's exact count and no mix with the abandoned one.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  localparam int unsigned OFS_GATE   = 0;
  localparam int unsigned OFS_STATUS = 1;
  localparam int unsigned OFS_RESULT = 2;
  localparam int unsigned GATE_MIN   = 16;
endpackage

// File: rtl/clkmon_rst_sync.sv
module clkmon_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= '0;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n = stg_q[1];
endmodule

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/clkmon_edge_counter.sv
module clkmon_edge_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] gray_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] gray_q, gray_d;

  always_comb begin
    cnt_d  = cnt_q + CNT_W'(1);
    gray_d = cnt_q ^ (cnt_q >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      gray_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      gray_q <= gray_d;
    end
  end

  assign gray_o = gray_q;
endmodule

// File: rtl/clkmon_ref_core.sv
module clkmon_ref_core
  import clkmon_pkg::*;
#(
  parameter int unsigned NCH      = 4,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned DEF_GATE = 50_000_000
) (
  input  logic                  ref_clk,
  input  logic                  ref_rst_n,
  input  logic [NCH*CNT_W-1:0]  gray_s_i,
  input  logic                  ctl_tgl_s_i,
  input  logic [DATA_W-1:0]     gate_len_i,
  output logic [DATA_W-1:0]     gate_len_o,
  output logic [NCH*CNT_W-1:0]  res_o,
  output logic [NCH-1:0]        res_tgl_o
);
  function automatic logic [CNT_W-1:0] gray2bin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = int'(CNT_W) - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic              ctl_prev_q;
  logic              ctl_evt;
  logic [DATA_W-1:0] gate_len_q, gate_len_d;
  logic [DATA_W-1:0] tmr_q, tmr_d;
  logic              armed_q, armed_d;
  logic              win_end;

  always_comb begin
    ctl_evt    = ctl_tgl_s_i ^ ctl_prev_q;
    win_end    = (tmr_q == gate_len_q - DATA_W'(1)) && !ctl_evt;
    tmr_d      = (ctl_evt || win_end) ? '0 : tmr_q + DATA_W'(1);
    gate_len_d = ctl_evt ? gate_len_i : gate_len_q;
    if (ctl_evt)      armed_d = 1'b0;
    else if (win_end) armed_d = 1'b1;
    else              armed_d = armed_q;
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      ctl_prev_q <= 1'b0;
      gate_len_q <= DATA_W'(DEF_GATE);
      tmr_q      <= '0;
      armed_q    <= 1'b0;
    end else begin
      ctl_prev_q <= ctl_tgl_s_i;
      gate_len_q <= gate_len_d;
      tmr_q      <= tmr_d;
      armed_q    <= armed_d;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [CNT_W-1:0] cur;
    logic [CNT_W-1:0] base_q, base_d;
    logic [CNT_W-1:0] res_q, res_d;
    logic             tgl_q, tgl_d;
    logic             res_en;

    always_comb begin
      cur    = gray2bin(gray_s_i[ch*CNT_W +: CNT_W]);
      res_en = win_end && armed_q;
      base_d = win_end ? cur : base_q;
      res_d  = res_en ? (cur - base_q) : res_q;
      tgl_d  = tgl_q ^ res_en;
    end

    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
      if (!ref_rst_n) begin
        base_q <= '0;
        res_q  <= '0;
        tgl_q  <= 1'b0;
      end else begin
        base_q <= base_d;
        res_q  <= res_d;
        tgl_q  <= tgl_d;
      end
    end

    assign res_o[ch*CNT_W +: CNT_W] = res_q;
    assign res_tgl_o[ch]            = tgl_q;
  end

  assign gate_len_o = gate_len_q;
endmodule

// File: rtl/clkmon_bus_regs.sv
module clkmon_bus_regs
  import clkmon_pkg::*;
#(
  parameter int unsigned NCH      = 4,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned DEF_GATE = 50_000_000,
  parameter int unsigned ADDR_W   = 3
) (
  input  logic                 bus_clk,
  input  logic                 bus_rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [DATA_W-1:0]    gate_len_o,
  output logic                 ctl_tgl_o,
  input  logic [NCH*CNT_W-1:0] res_i,
  input  logic [NCH-1:0]       res_tgl_s_i,
  output logic [NCH-1:0]       valid_o
);
  logic [DATA_W-1:0]    gate_q, gate_d;
  logic                 ctl_q, ctl_d;
  logic                 gate_we;
  logic [NCH-1:0]       tprev_q;
  logic [NCH-1:0]       res_evt;
  logic [NCH-1:0]       valid_q, valid_d;
  logic [NCH*CNT_W-1:0] res_bus_q, res_bus_d;
  logic [DATA_W-1:0]    rd_mux;
  logic [DATA_W-1:0]    rdata_q, rdata_d;

  always_comb begin
    gate_we = reg_wr && (reg_addr == ADDR_W'(OFS_GATE));
    if (gate_we)
      gate_d = (reg_wdata < DATA_W'(GATE_MIN)) ? DATA_W'(GATE_MIN) : reg_wdata;
    else
      gate_d = gate_q;
    ctl_d   = ctl_q ^ gate_we;
    res_evt = res_tgl_s_i ^ tprev_q;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic rd_hit;
    always_comb begin
      rd_hit = reg_rd && (reg_addr == ADDR_W'(OFS_RESULT + ch));
      if (res_evt[ch])  valid_d[ch] = 1'b1;
      else if (rd_hit)  valid_d[ch] = 1'b0;
      else              valid_d[ch] = valid_q[ch];
      res_bus_d[ch*CNT_W +: CNT_W] = res_evt[ch] ? res_i[ch*CNT_W +: CNT_W]
                                                 : res_bus_q[ch*CNT_W +: CNT_W];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(OFS_GATE)) begin
      rd_mux = gate_q;
    end else if (reg_addr == ADDR_W'(OFS_STATUS)) begin
      rd_mux[NCH-1:0] = valid_q;
    end else begin
      for (int c = 0; c < int'(NCH); c++) begin
        if (reg_addr == ADDR_W'(int'(OFS_RESULT) + c))
          rd_mux[CNT_W-1:0] = res_bus_q[c*CNT_W +: CNT_W];
      end
    end
    rdata_d = reg_rd ? rd_mux : rdata_q;
  end

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      gate_q    <= DATA_W'(DEF_GATE);
      ctl_q     <= 1'b0;
      tprev_q   <= '0;
      valid_q   <= '0;
      res_bus_q <= '0;
      rdata_q   <= '0;
    end else begin
      gate_q    <= gate_d;
      ctl_q     <= ctl_d;
      tprev_q   <= res_tgl_s_i;
      valid_q   <= valid_d;
      res_bus_q <= res_bus_d;
      rdata_q   <= rdata_d;
    end
  end

  assign reg_rdata  = rdata_q;
  assign gate_len_o = gate_q;
  assign ctl_tgl_o  = ctl_q;
  assign valid_o    = valid_q;
endmodule

// File: rtl/clkrate_monitor.sv
module clkrate_monitor
  import clkmon_pkg::*;
#(
  parameter  int unsigned NCH      = 4,
  parameter  int unsigned CNT_W    = 32,
  parameter  int unsigned DATA_W   = 32,
  parameter  int unsigned DEF_GATE = 50_000_000,
  localparam int unsigned ADDR_W   = $clog2(NCH + OFS_RESULT)
) (
  input  logic              arst_n,
  input  logic              bus_clk,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ref_clk,
  input  logic [NCH-1:0]    meas_clk
);
  logic                 bus_rst_n;
  logic                 ref_rst_n;
  logic [NCH-1:0]       meas_rst_n;
  logic [NCH*CNT_W-1:0] gray_src;
  logic [NCH*CNT_W-1:0] gray_ref;
  logic [DATA_W-1:0]    gate_len_bus;
  logic [DATA_W-1:0]    gate_len_ref;
  logic                 ctl_tgl_bus;
  logic                 ctl_tgl_s;
  logic [NCH*CNT_W-1:0] res_ref;
  logic [NCH-1:0]       res_tgl_ref;
  logic [NCH-1:0]       res_tgl_s;
  logic [NCH-1:0]       valid;

  clkmon_rst_sync u_rst_bus (.clk(bus_clk), .arst_n(arst_n), .rst_n(bus_rst_n));
  clkmon_rst_sync u_rst_ref (.clk(ref_clk), .arst_n(arst_n), .rst_n(ref_rst_n));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_meas
    clkmon_rst_sync u_rst (
      .clk(meas_clk[ch]), .arst_n(arst_n), .rst_n(meas_rst_n[ch])
    );
    clkmon_edge_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(meas_clk[ch]), .rst_n(meas_rst_n[ch]),
      .gray_o(gray_src[ch*CNT_W +: CNT_W])
    );
  end

  clkmon_sync #(.W(NCH*CNT_W)) u_sync_gray (
    .clk(ref_clk), .rst_n(ref_rst_n), .d_i(gray_src), .q_o(gray_ref)
  );
  clkmon_sync #(.W(1)) u_sync_ctl (
    .clk(ref_clk), .rst_n(ref_rst_n), .d_i(ctl_tgl_bus), .q_o(ctl_tgl_s)
  );
  clkmon_sync #(.W(NCH)) u_sync_res (
    .clk(bus_clk), .rst_n(bus_rst_n), .d_i(res_tgl_ref), .q_o(res_tgl_s)
  );

  clkmon_ref_core #(
    .NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W), .DEF_GATE(DEF_GATE)
  ) u_ref (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
    .gray_s_i(gray_ref), .ctl_tgl_s_i(ctl_tgl_s),
    .gate_len_i(gate_len_bus), .gate_len_o(gate_len_ref),
    .res_o(res_ref), .res_tgl_o(res_tgl_ref)
  );

  clkmon_bus_regs #(
    .NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W), .DEF_GATE(DEF_GATE), .ADDR_W(ADDR_W)
  ) u_bus (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gate_len_o(gate_len_bus), .ctl_tgl_o(ctl_tgl_bus),
    .res_i(res_ref), .res_tgl_s_i(res_tgl_s), .valid_o(valid)
  );
endmodule

// File: rtl/clkmon_checker.sv
module clkmon_checker
  import clkmon_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic                 bus_clk,
  input logic                 bus_rst_n,
  input logic                 ref_clk,
  input logic                 ref_rst_n,
  input logic [NCH-1:0]       meas_clk,
  input logic [NCH-1:0]       meas_rst_n,
  input logic [NCH*CNT_W-1:0] gray_src,
  input logic                 reg_rd,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [NCH-1:0]       res_tgl_s,
  input logic [NCH-1:0]       valid,
  input logic [DATA_W-1:0]    gate_len_ref,
  input logic [NCH*CNT_W-1:0] res_ref,
  input logic [NCH-1:0]       res_tgl_ref
);
  AST_GATE_FLOOR: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    gate_len_ref >= DATA_W'(GATE_MIN)); // R3

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    AST_VALID_ON_ARRIVAL: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (res_tgl_s[i] != $past(res_tgl_s[i])) |=> valid[i]); // R6

    AST_READ_CLEARS: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (reg_rd && (reg_addr == ADDR_W'(OFS_RESULT + i)) && (res_tgl_s[i] == $past(res_tgl_s[i])))
      |=> !valid[i]); // R6

    AST_RESULT_HOLD: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      $stable(res_tgl_ref[i]) |-> $stable(res_ref[i*CNT_W +: CNT_W])); // R10

    AST_GRAY_STEP: assert property (@(posedge meas_clk[i]) disable iff (!meas_rst_n[i])
      $countones(gray_src[i*CNT_W +: CNT_W] ^ $past(gray_src[i*CNT_W +: CNT_W])) <= 1); // R9
  end
endmodule

bind clkrate_monitor clkmon_checker #(
  .NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_clkmon_checker (
  .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
  .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
  .meas_clk(meas_clk), .meas_rst_n(meas_rst_n),
  .gray_src(gray_src), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .res_tgl_s(res_tgl_s), .valid(valid), .gate_len_ref(gate_len_ref),
  .res_ref(res_ref), .res_tgl_ref(res_tgl_ref)
);

// File: tb/test_clkrate_monitor.sv
`timescale 1ns/1ps
module test_clkrate_monitor;
  localparam int NCH    = 4;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int REF_PER = 10;
  localparam int P0 = 20;
  localparam int P1 = 30;
  localparam int P2 = 14;

  logic              arst_n;
  logic              bus_clk;
  logic              ref_clk;
  logic              reg_wr, reg_rd;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] reg_wdata;
  logic [DATA_W-1:0] reg_rdata;
  logic              mc0, mc1, mc2, mc3;
  logic [NCH-1:0]    meas_clk;

  int  n_checks = 0;
  int  n_err    = 0;
  bit  done     = 0;

  assign meas_clk = {mc3, mc2, mc1, mc0};

  clkrate_monitor #(.NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W)) i_clkrate_monitor (
    .arst_n(arst_n), .bus_clk(bus_clk), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ref_clk(ref_clk), .meas_clk(meas_clk)
  );

  initial begin bus_clk = 0; forever #2 bus_clk = ~bus_clk; end
  initial begin ref_clk = 0; forever #5 ref_clk = ~ref_clk; end
  initial begin mc0 = 0; #1; forever #(P0/2) mc0 = ~mc0; end
  initial begin mc1 = 0; #1; forever #(P1/2) mc1 = ~mc1; end
  initial begin mc2 = 0; #2; forever #(P2/2) mc2 = ~mc2; end
  initial mc3 = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input int d);
    @(negedge bus_clk);
    reg_wr = 1; reg_addr = ADDR_W'(a); reg_wdata = DATA_W'(d);
    @(negedge bus_clk);
    reg_wr = 0;
  endtask

  task automatic bus_read(input int a, output int d);
    @(negedge bus_clk);
    reg_rd = 1; reg_addr = ADDR_W'(a);
    @(negedge bus_clk);
    reg_rd = 0;
    d = int'(reg_rdata);
  endtask

  task automatic poll(input int mask, input int limit, output bit ok, output int iters);
    int d;
    ok = 0; iters = 0;
    while (!ok && iters < limit) begin
      bus_read(1, d);
      iters++;
      if ((d & mask) == mask) ok = 1;
    end
  endtask

  task automatic clear_all();
    int d;
    for (int c = 0; c < NCH; c++) bus_read(2 + c, d);
  endtask

  // expected edge count for a window of g reference cycles, modulo 2^CNT_W
  function automatic bit near(input int act, input int g, input int p);
    int num = g * REF_PER;
    if (num % p == 0) return act == ((num / p) % 256);
    return (act * p > num - p) && (act * p < num + p);
  endfunction

  task automatic run_window(input int wval, input int g);
    int  d;
    bit  ok;
    int  it;
    bus_write(0, wval);
    bus_read(0, d);
    check(d == g, "R3 gate readback", d, g);
    repeat (3 * g + 10) @(posedge ref_clk);
    clear_all();
    poll(4'hF, g * REF_PER / 4 + 100, ok, it);
    check(ok, "R10 all channels refreshed", it, 0);
    bus_read(2, d);
    check(near(d, g, P0), "R4 ch0 count", d, g * REF_PER / P0);
    bus_read(3, d);
    check(near(d, g, P1), "R4 ch1 count", d, g * REF_PER / P1);
    bus_read(4, d);
    check(near(d, g, P2), "R4 ch2 count", d, g * REF_PER / P2);
    bus_read(5, d);
    check(d == 0, "R7 stopped clock", d, 0);
  endtask

  initial begin
    int d;
    bit ok;
    int it;
    arst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    #103;
    arst_n = 1;
    repeat (20) @(negedge bus_clk);

    // R1 reset state, R2 map
    bus_read(0, d); check(d == 50_000_000, "R1 gate default", d, 50_000_000);
    bus_read(1, d); check(d == 0, "R1 status after reset", d, 0);
    for (int c = 0; c < NCH; c++) begin
      bus_read(2 + c, d); check(d == 0, "R1 result after reset", d, 0);
    end
    bus_read(6, d); check(d == 0, "R2 unmapped offset 6", d, 0);
    bus_read(7, d); check(d == 0, "R2 unmapped offset 7", d, 0);

    // R3 clamp, then measure at the floor
    run_window(5, 16);
    run_window(0, 16);

    // R4 sweep of gate lengths
    for (int g = 18; g <= 72; g += 6) run_window(g, g);

    // R8 counter wrap: 600 cycles -> ch0 300 edges -> 44 mod 256
    bus_write(0, 600);
    repeat (3 * 600 + 10) @(posedge ref_clk);
    clear_all();
    poll(4'hF, 600 * REF_PER / 4 + 100, ok, it);
    check(ok, "R10 refresh long window", it, 0);
    bus_read(2, d); check(d == 44, "R8 ch0 wrapped count", d, 44);
    bus_read(3, d); check(d == 200, "R8 ch1 count", d, 200);
    bus_read(5, d); check(d == 0, "R7 stopped clock long window", d, 0);

    // R6 valid set/clear with a long window
    bus_write(0, 2000);
    repeat (3 * 2000 + 10) @(posedge ref_clk);
    clear_all();
    poll(4'hF, 2000 * REF_PER / 4 + 100, ok, it);
    check(ok, "R6 valid set on arrival", it, 0);
    bus_read(2, d);
    check(d == 1000 % 256, "R4 ch0 long window", d, 1000 % 256);
    bus_read(1, d);
    check(d == 4'hE, "R6 read clears only own flag", d, 4'hE);
    clear_all();
    bus_read(1, d);
    check(d == 0, "R6 all flags cleared", d, 0);
    // R10 next window arrives within one window time
    poll(4'hF, 2000 * REF_PER / 8 + 50, ok, it);
    check(ok, "R10 next window on time", it, 2000 * REF_PER / 8);

    // R5 restart: write short gate right after a fresh result
    clear_all();
    bus_write(0, 40);
    poll(4'h1, 40 * 3 + 100, ok, it);
    check(ok, "R5 result after restart", it, 0);
    bus_read(2, d);
    check(d == 20, "R5 first window after write is full", d, 20);
    bus_read(5, d);
    check(d == 0, "R7 stopped clock after restart", d, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #600_000;
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule